// File: doc/BRIEF.md
# Receive Descriptor Ring Writeback Engine

This block is the receive side of a bus-master network controller. It moves incoming frames into host memory through a ring of 16-byte descriptors. Each descriptor has four words: a status word at offset 0, a control word at +4, a buffer address at +8 and a next pointer at +12. The engine does not use the next pointer. When the first byte of a frame arrives, the engine holds the byte stream and reads the current descriptor. If the device owns that descriptor, it reads the control word and the buffer address. It then packs the frame bytes into 32-bit little-endian words and writes them to the buffer. It finishes with a status write that returns the descriptor to the host.

The host supplies a 32-bit ring base address and a receive enable. The memory port is a single-beat port with per-byte write strobes. Read data arrives exactly one cycle after a read request. If the device does not own the current descriptor, the engine consumes and discards the frame and counts it as missed. A 3-bit process state output shows what the engine is doing.

Top module: `rx_ring_engine`

## Requirements
- R1: After reset the engine is stopped: `proc_state` = 0, `in_ready` = 0, `mem_req` = 0 and `miss_count` = 0.
- R2: When `rx_en` rises from the stopped state, the current descriptor becomes `ring_base` with its low 5 bits forced to zero (32-byte alignment). The first frame after that uses this descriptor.
- R3: Ownership is status bit 31 (1 = device owns it). For an owned descriptor, frame byte k goes to the buffer word at buffer address + 4*(k/4), byte lane k%4 (bits 8*(k%4)+7 : 8*(k%4)). The low 2 bits of the buffer address are ignored.
- R4: Control bits 10:0 give the buffer size in bytes. No byte at an offset equal to or above the size is written, and a frame longer than the buffer sets the error summary. A size of 0 writes no data.
- R5: The written-back status word is laid out as follows:
  - bits 30:16 hold the frame byte count, including the 4-byte check sequence carried in the stream;
  - bit 15 is set when any byte had `in_err` or the frame overflowed the buffer;
  - bit 8 is set;
  - bit 31 and all other bits are zero.
- R6: The status write is the last memory write of a frame. No buffer write follows it.
- R7: After a frame completes, the engine moves to the next descriptor at +16 bytes. If control bit 25 was set, it returns to the aligned ring base instead.
- R8: If the current descriptor is host-owned when a frame starts, the engine consumes the frame without any memory write. `miss_count` increments by 1, and the next frame tries the same descriptor again.
- R9: Clearing `rx_en` during a frame lets that frame complete and write back. The engine then stops: `proc_state` = 0 and `in_ready` = 0. Re-enabling restarts at the ring base.
- R10: `proc_state` codes are:
  - 0: stopped;
  - 1: reading the descriptor;
  - 2: storing frame data;
  - 3: writing status;
  - 4: discarding an unowned frame;
  - 5: running and waiting for a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive enable |
| ring_base | input | 32 | Ring base address (low 5 bits ignored) |
| in_valid | input | 1 | Frame byte valid |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Final byte of the frame |
| in_err | input | 1 | Byte carries an error mark |
| in_ready | output | 1 | Byte accepted when high with `in_valid` |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write (1) or read (0) |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_wstrb | output | 4 | Byte-lane write strobes |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| miss_count | output | 16 | Count of frames dropped for lack of a descriptor |
| proc_state | output | 3 | Process state code |

## Verification
A wrong descriptor pointer shows up when the next frame completes. The status word lands on the wrong descriptor, and a neighbouring descriptor's ownership bit is disturbed. A stale byte count or lane index shows up as corrupted buffer bytes, or as writes past the buffer size, within the same frame. A lost error or overflow flag appears at the status write, one cycle after the last byte. Status writes that come too early, and dropped frames that still write memory, are caught by watching the order and number of writes during each frame.

// File: rtl/rx_ring_pkg.sv
`timescale 1ns/1ps
package rx_ring_pkg;
    localparam int LEN_W     = 15;
    localparam int SIZE_W    = 11;
    localparam int OWN_BIT   = 31;
    localparam int EOR_BIT   = 25;
    localparam int ERR_BIT   = 15;
    localparam int LAST_BIT  = 8;
    localparam int DESC_STEP = 16;
    localparam int RING_ALIGN = 32;

    typedef enum logic [3:0] {
        ST_STOP, ST_IDLE, ST_CHK_STS, ST_CHK_CTL, ST_CHK_BUF,
        ST_DATA, ST_STATUS, ST_DROP
    } eng_state_e;

    typedef struct packed {
        logic              wrap;
        logic [SIZE_W-1:0] size;
    } ctl_t;

    function automatic logic [2:0] proc_code(eng_state_e s);
        case (s)
            ST_STOP:                          return 3'd0;
            ST_CHK_STS, ST_CHK_CTL, ST_CHK_BUF: return 3'd1;
            ST_DATA:                          return 3'd2;
            ST_STATUS:                        return 3'd3;
            ST_DROP:                          return 3'd4;
            default:                          return 3'd5;
        endcase
    endfunction

    function automatic logic [31:0] build_status(logic [LEN_W-1:0] len, logic es);
        return {1'b0, len, es, 6'b0, 1'b1, 8'b0};
    endfunction
endpackage

// File: rtl/rx_ring_ptr.sv
`timescale 1ns/1ps
module rx_ring_ptr #(
    parameter int AW     = 32,
    parameter int STRIDE = 16,
    parameter int ALIGN  = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          step,
    input  logic          wrap,
    input  logic [AW-1:0] base,
    output logic [AW-1:0] cur
);
    localparam int STRIDE_LSB = $clog2(STRIDE);
    logic [AW-1:0] base_al;

    assign base_al = base & ~AW'(ALIGN - 1);

    always_ff @(posedge clk) begin
        if (rst)       cur <= '0;
        else if (load) cur <= base_al;
        else if (step) cur <= wrap ? base_al : cur + AW'(STRIDE);
    end

    AST_PTR_ON_SLOT: assert property (@(posedge clk) disable iff (rst)
        cur[STRIDE_LSB-1:0] == '0); // R7
    AST_WRAP_TO_BASE: assert property (@(posedge clk) disable iff (rst)
        (step && wrap && !load) |=> cur == $past(base_al)); // R7
endmodule

// File: rtl/rx_byte_packer.sv
`timescale 1ns/1ps
module rx_byte_packer #(
    parameter int LEN_W  = 15,
    parameter int SIZE_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              take,
    input  logic              last,
    input  logic [7:0]        din,
    input  logic [SIZE_W-1:0] size_lim,
    output logic              wr_en,
    output logic [31:0]       wr_word,
    output logic [3:0]        wr_strb,
    output logic [LEN_W-3:0]  wr_idx,
    output logic [LEN_W-1:0]  count,
    output logic              over_now
);
    logic [31:0]      acc;
    logic             over_q;
    logic [1:0]       lane;
    logic             room;
    logic [LEN_W-1:0] cnt_nx;
    logic [LEN_W-1:0] lim;

    assign lane   = count[1:0];
    assign lim    = LEN_W'(size_lim);
    assign room   = count < lim;
    assign cnt_nx = count + 1'b1;
    assign wr_idx = count[LEN_W-1:2];
    assign wr_word = ((lane == 2'd0) ? 32'h0 : acc) | (32'(din) << {lane, 3'b000});
    assign wr_en  = take && room && (lane == 2'd3 || last || cnt_nx == lim);
    assign over_now = over_q || (take && !room);

    always_comb begin
        case (lane)
            2'd0:    wr_strb = 4'b0001;
            2'd1:    wr_strb = 4'b0011;
            2'd2:    wr_strb = 4'b0111;
            default: wr_strb = 4'b1111;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count  <= '0;
            acc    <= '0;
            over_q <= 1'b0;
        end else if (take) begin
            count  <= cnt_nx;
            over_q <= over_now;
            if (room) acc <= wr_word;
        end
    end

    AST_OVER_STICKY: assert property (@(posedge clk) disable iff (rst)
        (over_q && !clear) |=> over_q); // R4
endmodule

// File: rtl/rx_ring_engine.sv
`timescale 1ns/1ps
module rx_ring_engine
    import rx_ring_pkg::*;
#(
    parameter int MISS_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_en,
    input  logic [31:0]       ring_base,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    input  logic              in_err,
    output logic              in_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [31:0]       mem_addr,
    output logic [31:0]       mem_wdata,
    output logic [3:0]        mem_wstrb,
    input  logic [31:0]       mem_rdata,
    output logic [MISS_W-1:0] miss_count,
    output logic [2:0]        proc_state
);
    eng_state_e       state, state_nx;
    ctl_t             ctl_q;
    logic [31:0]      buf_base;
    logic             err_seen;
    logic [LEN_W-1:0] len_q;
    logic             es_q;
    logic [31:0]      cur;

    logic             take;
    logic             pk_wr;
    logic [31:0]      pk_word;
    logic [3:0]       pk_strb;
    logic [LEN_W-3:0] pk_idx;
    logic [LEN_W-1:0] pk_count;
    logic             pk_over;

    assign in_ready   = (state == ST_DATA) || (state == ST_DROP);
    assign take       = in_ready && in_valid;
    assign proc_state = proc_code(state);

    rx_ring_ptr #(.AW(32), .STRIDE(DESC_STEP), .ALIGN(RING_ALIGN)) u_ptr (
        .clk  (clk),
        .rst  (rst),
        .load (state == ST_STOP && rx_en),
        .step (state == ST_STATUS),
        .wrap (ctl_q.wrap),
        .base (ring_base),
        .cur  (cur)
    );

    rx_byte_packer #(.LEN_W(LEN_W), .SIZE_W(SIZE_W)) u_pack (
        .clk      (clk),
        .rst      (rst),
        .clear    (state == ST_CHK_BUF),
        .take     (take && state == ST_DATA),
        .last     (in_last),
        .din      (in_data),
        .size_lim (ctl_q.size),
        .wr_en    (pk_wr),
        .wr_word  (pk_word),
        .wr_strb  (pk_strb),
        .wr_idx   (pk_idx),
        .count    (pk_count),
        .over_now (pk_over)
    );

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        mem_wstrb = '0;
        state_nx  = state;
        case (state)
            ST_STOP: if (rx_en) state_nx = ST_IDLE;
            ST_IDLE: begin
                if (!rx_en) state_nx = ST_STOP;
                else if (in_valid) begin
                    mem_req  = 1'b1;
                    mem_addr = cur;
                    state_nx = ST_CHK_STS;
                end
            end
            ST_CHK_STS: begin
                if (mem_rdata[OWN_BIT]) begin
                    mem_req  = 1'b1;
                    mem_addr = cur + 32'd4;
                    state_nx = ST_CHK_CTL;
                end else begin
                    state_nx = ST_DROP;
                end
            end
            ST_CHK_CTL: begin
                mem_req  = 1'b1;
                mem_addr = cur + 32'd8;
                state_nx = ST_CHK_BUF;
            end
            ST_CHK_BUF: state_nx = ST_DATA;
            ST_DATA: begin
                if (pk_wr) begin
                    mem_req   = 1'b1;
                    mem_we    = 1'b1;
                    mem_addr  = buf_base + {{(32-LEN_W){1'b0}}, pk_idx, 2'b00};
                    mem_wdata = pk_word;
                    mem_wstrb = pk_strb;
                end
                if (take && in_last) state_nx = ST_STATUS;
            end
            ST_STATUS: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cur;
                mem_wdata = build_status(len_q, es_q);
                mem_wstrb = 4'hF;
                state_nx  = ST_IDLE;
            end
            ST_DROP: if (take && in_last) state_nx = ST_IDLE;
            default: state_nx = ST_STOP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_STOP;
            ctl_q      <= '0;
            buf_base   <= '0;
            err_seen   <= 1'b0;
            len_q      <= '0;
            es_q       <= 1'b0;
            miss_count <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_CHK_STS && !mem_rdata[OWN_BIT])
                miss_count <= miss_count + 1'b1;
            if (state == ST_CHK_CTL) begin
                ctl_q.size <= mem_rdata[SIZE_W-1:0];
                ctl_q.wrap <= mem_rdata[EOR_BIT];
            end
            if (state == ST_CHK_BUF) begin
                buf_base <= mem_rdata & ~32'h3;
                err_seen <= 1'b0;
            end
            if (state == ST_DATA && take) begin
                err_seen <= err_seen || in_err;
                if (in_last) begin
                    len_q <= pk_count + 1'b1;
                    es_q  <= err_seen || in_err || pk_over;
                end
            end
        end
    end

    AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (state == ST_STOP) |-> (!in_ready && !mem_req)); // R9
    AST_MISS_ON_UNOWNED: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CHK_STS && !mem_rdata[OWN_BIT]) |=> miss_count == $past(miss_count) + 1'b1); // R8
    AST_DROP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DROP) |-> !mem_we); // R8
    AST_STATUS_RETURNS_OWN: assert property (@(posedge clk) disable iff (rst)
        (mem_we && mem_addr == cur) |-> (!mem_wdata[OWN_BIT] && mem_wdata[LAST_BIT])); // R5
    AST_DATA_IN_BUF: assert property (@(posedge clk) disable iff (rst)
        (mem_we && state == ST_DATA) |-> (mem_addr - buf_base) < {21'b0, ctl_q.size}); // R4
    AST_NO_WRITE_AFTER_STATUS: assert property (@(posedge clk) disable iff (rst)
        (state == ST_STATUS) |=> !mem_we); // R6
endmodule

// File: tb/tb_rx_ring_engine.sv
`timescale 1ns/1ps
module tb_rx_ring_engine;
    localparam logic [31:0] RING    = 32'h0000_0053;
    localparam logic [31:0] RING_AL = 32'h0000_0040;
    localparam logic [31:0] BUF0    = 32'h0000_0200;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_en = 1'b0;
    logic [31:0] ring_base = RING;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h0;
    logic        in_last = 1'b0;
    logic        in_err = 1'b0;
    logic        in_ready;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [3:0]  mem_wstrb;
    logic [31:0] mem_rdata = 32'h0;
    logic [15:0] miss_count;
    logic [2:0]  proc_state;

    logic [31:0] mem [0:255];
    logic        host_we = 1'b0;
    logic [31:0] host_addr = 32'h0;
    logic [31:0] host_data = 32'h0;
    logic        mon_clr = 1'b0;
    int          wr_cnt = 0;
    bit          sts_seen = 1'b0;
    int          order_bad = 0;

    int          n_tests = 0;
    int          n_fail = 0;
    int          exp_d = 0;
    logic [7:0]  frame [0:63];

    always #2.5 clk = ~clk;

    rx_ring_engine dut (
        .clk(clk), .rst(rst), .rx_en(rx_en), .ring_base(ring_base),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_err(in_err),
        .in_ready(in_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_wstrb(mem_wstrb), .mem_rdata(mem_rdata),
        .miss_count(miss_count), .proc_state(proc_state)
    );

    always @(posedge clk) begin
        if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[9:2]];
        if (host_we) mem[host_addr[9:2]] <= host_data;
        if (mon_clr) begin
            wr_cnt <= 0; sts_seen <= 1'b0; order_bad <= 0;
        end else if (mem_req && mem_we) begin
            for (int b = 0; b < 4; b++)
                if (mem_wstrb[b]) mem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
            wr_cnt <= wr_cnt + 1;
            if (mem_addr < BUF0) sts_seen <= 1'b1;
            else if (sts_seen) order_bad <= order_bad + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] desc_a(input int d);
        return RING_AL + 32'(d * 16);
    endfunction

    function automatic logic [31:0] buf_a(input int d);
        return BUF0 + 32'(d * 64);
    endfunction

    function automatic logic [31:0] exp_status(input int len, input bit es);
        return (32'(len) << 16) | (32'(es) << 15) | 32'h100;
    endfunction

    task automatic hwrite(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk); host_we = 1'b1; host_addr = a; host_data = d;
        @(negedge clk); host_we = 1'b0;
    endtask

    task automatic arm_all(input int size);
        for (int d = 0; d < 3; d++) begin
            hwrite(desc_a(d), 32'h8000_0000);
            hwrite(desc_a(d) + 4, ((d == 2) ? 32'h0200_0000 : 32'h0) | 32'(size));
            hwrite(desc_a(d) + 8, buf_a(d) | 32'h1);
            for (int w = 0; w < 16; w++) hwrite(buf_a(d) + 32'(4 * w), 32'hEEEE_EEEE);
        end
    endtask

    task automatic send_frame(input int len, input int errpos, input int dis_at, input int code);
        @(negedge clk); mon_clr = 1'b1;
        @(negedge clk); mon_clr = 1'b0;
        for (int i = 0; i < len; i++) begin
            frame[i] = 8'($urandom);
            @(negedge clk);
            if (i == dis_at) rx_en = 1'b0;
            in_valid = 1'b1; in_data = frame[i];
            in_last = (i == len - 1); in_err = (i == errpos);
            while (!in_ready) @(negedge clk);
            if (i == 0) chk(proc_state == 3'(code), "R10", "state while taking bytes", 32'(proc_state), 32'(code));
            @(posedge clk);
        end
        @(negedge clk); in_valid = 1'b0; in_last = 1'b0; in_err = 1'b0;
        for (int k = 0; k < 40 && !(proc_state == 3'd5 || proc_state == 3'd0); k++) @(negedge clk);
    endtask

    task automatic check_frame(input int d, input int len, input int size, input bit es, input string req);
        int stored;
        int bad;
        logic [7:0] got;
        stored = (len < size) ? len : size;
        bad = 0;
        chk(mem[desc_a(d) >> 2] == exp_status(len, es), req, "status word",
            mem[desc_a(d) >> 2], exp_status(len, es));
        for (int k = 0; k < 64; k++) begin
            got = mem[(buf_a(d) >> 2) + 32'(k / 4)][8 * (k % 4) +: 8];
            if (k < stored) begin if (got != frame[k]) bad++; end
            else if (got != 8'hEE) bad++;
        end
        chk(bad == 0, "R3", "buffer bytes mismatched", 32'(bad), 32'h0);
        chk(order_bad == 0 && sts_seen, "R6", "writes after status", 32'(order_bad), 32'h0);
        for (int o = 0; o < 3; o++)
            if (o != d) chk(mem[desc_a(o) >> 2] == 32'h8000_0000, "R7", "other descriptor touched",
                            mem[desc_a(o) >> 2], 32'h8000_0000);
    endtask

    task automatic advance();
        exp_d = (exp_d == 2) ? 0 : exp_d + 1;
    endtask

    initial begin
        #1ms;
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int len;
        int ep;
        int m0;
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(proc_state == 3'd0 && !in_ready && !mem_req && miss_count == 16'd0, "R1", "reset outputs",
            {proc_state, in_ready, mem_req, miss_count}, 32'h0);

        arm_all(48);
        rx_en = 1'b1;
        repeat (2) @(negedge clk);
        chk(proc_state == 3'd5, "R10", "waiting code", 32'(proc_state), 32'd5);

        // R2: first frame lands at aligned ring base
        send_frame(8, -1, -1, 2);
        check_frame(0, 8, 48, 1'b0, "R2");
        advance();

        // random frames, R5 and R7 wrap
        for (int f = 0; f < 12; f++) begin
            arm_all(48);
            len = $urandom_range(1, 40);
            ep = ($urandom % 4 == 0) ? int'($urandom_range(0, len - 1)) : -1;
            send_frame(len, ep, -1, 2);
            check_frame(exp_d, len, 48, ep >= 0, "R5");
            advance();
        end

        // R4: overflow of a 6-byte buffer
        arm_all(6);
        send_frame(10, -1, -1, 2);
        check_frame(exp_d, 10, 6, 1'b1, "R4");
        advance();

        // R4: zero-size buffer
        arm_all(0);
        send_frame(3, -1, -1, 2);
        check_frame(exp_d, 3, 0, 1'b1, "R4");
        chk(wr_cnt == 1, "R4", "write count for zero size", 32'(wr_cnt), 32'd1);
        advance();

        // R8: host-owned descriptor
        arm_all(48);
        hwrite(desc_a(exp_d), 32'h0);
        m0 = int'(miss_count);
        send_frame(5, -1, -1, 4);
        chk(int'(miss_count) == m0 + 1, "R8", "miss count", 32'(miss_count), 32'(m0 + 1));
        chk(wr_cnt == 0, "R8", "writes on drop", 32'(wr_cnt), 32'h0);
        chk(mem[desc_a(exp_d) >> 2] == 32'h0, "R8", "unowned status kept", mem[desc_a(exp_d) >> 2], 32'h0);
        arm_all(48);
        send_frame(4, -1, -1, 2);
        check_frame(exp_d, 4, 48, 1'b0, "R8");
        advance();

        // R9: stop at frame boundary, restart at base
        while (exp_d != 0) begin
            arm_all(48);
            send_frame(2, -1, -1, 2);
            check_frame(exp_d, 2, 48, 1'b0, "R7");
            advance();
        end
        arm_all(48);
        send_frame(8, -1, 3, 2);
        check_frame(0, 8, 48, 1'b0, "R9");
        repeat (3) @(negedge clk);
        chk(proc_state == 3'd0 && !in_ready, "R9", "stopped after frame", {proc_state, in_ready}, 32'h0);
        rx_en = 1'b1;
        arm_all(48);
        send_frame(6, -1, -1, 2);
        check_frame(0, 6, 48, 1'b0, "R9");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule